// File: doc/BRIEF.md
# Secure Boot Gating Sequencer

This block sits between the boot flash and a host processor and keeps the host in reset until a fixed chain of three boot checks has succeeded. First it presents a fixed flash address and asks an external public-key engine to verify the signature stored there. If that passes, it starts an external hash engine over the flash image and compares the 256-bit digest it returns with a reference digest from on-chip non-volatile storage. If that matches, it asks the external decrypt path to confirm that it can decode the image with the on-chip key. Only then does it release the host and steer host flash reads through the decrypt path.

Each engine is reached through a one-cycle start pulse and answers with a done pulse and a pass bit. The stage cannot stall the sequence, because a watchdog turns a missing answer into a timeout. A stage that fails or times out ends the sequence for good, until the next power-on reset. The outcome of each stage is kept in a status register that maintenance software can read later. Per-stage LEDs can show progress, and a configuration input selects whether a failure also removes the supply enables.

Top module: `sboot_gate`

## Requirements
- R1: While `rst_n` is low, `host_rst_n` and `dec_route_en` are 0, `status_log` is all zeros, `led_stage` is 0 and every `supply_en` bit is 1.
- R2: In the second cycle after `rst_n` rises, `sig_start` is high for exactly one cycle, with `sig_addr` equal to the `SIG_ADDR` parameter.
- R3: `hash_start` pulses only after the signature stage has passed, and `dec_start` pulses only after the hash stage has passed. A failed or timed-out stage starts no later stage.
- R4: The hash stage fails when `hash_digest` differs from `ref_digest` in the cycle of `hash_done`.
- R5: A failed or timed-out stage of any kind, the decrypt stage included, leaves `host_rst_n` low.
- R6: After all three stages have passed, `host_rst_n` and `dec_route_en` are 1.
- R7: `status_log` holds 2 bits per stage: signature in bits 1:0, hash in bits 3:2 and decrypt in bits 5:4. Each field reads 00 not run, 01 pass, 10 fail, 11 timeout.
- R8: If a stage sees no done pulse within `WDOG_CYCLES` cycles of waiting, its field becomes 11 and the sequence stops.
- R9: After a failure with `cfg_cut_supply`=1, `supply_en` is all zeros. With `cfg_cut_supply`=0 it stays all ones.
- R10: `led_stage[i]` is 1 exactly when stage i's field is 01 and `cfg_led_en` is 1.
- R11: A `recheck` pulse after boot asserts `host_rst_n` low again, clears `status_log` and the LEDs, and restarts the chain at the signature stage.
- R12: After a failure, `recheck` is ignored. The status, the host reset and the engine starts stay unchanged until `rst_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| cfg_cut_supply | input | 1 | Failure removes supply enables when 1 |
| cfg_led_en | input | 1 | Enables per-stage pass LEDs |
| recheck | input | 1 | Soft request to re-run the checks after boot |
| sig_start | output | 1 | Start pulse to the signature verify engine |
| sig_addr | output | ADDR_W | Flash address of the stored signature |
| sig_done | input | 1 | Signature engine finished |
| sig_pass | input | 1 | Signature valid, qualified by sig_done |
| hash_start | output | 1 | Start pulse to the hash engine |
| img_base | output | ADDR_W | First flash address of the image |
| img_len | output | ADDR_W | Image length in bytes |
| hash_done | input | 1 | Hash engine finished |
| hash_digest | input | DIGEST_W | Digest returned with hash_done |
| ref_digest | input | DIGEST_W | Reference digest from non-volatile storage |
| dec_start | output | 1 | Start pulse to the decrypt path check |
| dec_done | input | 1 | Decrypt check finished |
| dec_pass | input | 1 | Image decodes with the on-chip key |
| host_rst_n | output | 1 | Host reset, active low |
| dec_route_en | output | 1 | Steers host flash reads through the decrypt path |
| led_stage | output | 3 | Per-stage pass indicators |
| supply_en | output | N_SUPPLY | Supply enable outputs |
| status_log | output | 6 | Per-stage result fields |

## Verification
The bench goes after stage ordering under every failure point: a failure in the signature stage, in the hash stage or in the decrypt stage, each as an explicit fail and as a silent engine. A design that started the next engine early, or that moved on after a timeout, would show extra start pulses or a released host. Digest mismatch is driven by flipping a single bit, so a comparison that checks only part of the digest lets the host boot. The recheck paths are tested from both end states: a sticky-failure design that honoured `recheck` would restart the signature engine, and a booted design that kept its old log would show stale 01 fields after the restart.

// File: rtl/sboot_pkg.sv
package sboot_pkg;

   localparam int unsigned N_STAGE = 3;
   localparam int unsigned STG_W   = 2;

   typedef enum logic [1:0] {
      RES_NONE = 2'b00,
      RES_PASS = 2'b01,
      RES_FAIL = 2'b10,
      RES_TMO  = 2'b11
   } stage_res_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_GO,
      S_WAIT,
      S_OK,
      S_FAIL
   } seq_st_e;

endpackage

// File: rtl/sboot_wdog.sv
module sboot_wdog #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int unsigned CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (!expired) cnt_q <= cnt_q + CW'(1);
   end

   assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/sboot_log.sv
module sboot_log
   import sboot_pkg::*;
#(
   parameter int unsigned N = N_STAGE
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           we,
   input  logic [STG_W-1:0] idx,
   input  stage_res_e     val,
   output logic [2*N-1:0] log_o
);
   for (genvar i = 0; i < N; i++) begin : g_field
      logic [1:0] fld_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                            fld_q <= RES_NONE;
         else if (clr)                          fld_q <= RES_NONE;
         else if (we && idx == STG_W'(i))       fld_q <= val;
      end
      assign log_o[2*i +: 2] = fld_q;
   end
endmodule

// File: rtl/sboot_gate.sv
module sboot_gate
   import sboot_pkg::*;
#(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned DIGEST_W    = 256,
   parameter int unsigned WDOG_CYCLES = 1000,
   parameter int unsigned N_SUPPLY    = 4,
   parameter logic [ADDR_W-1:0] SIG_ADDR = 24'h0F_F000,
   parameter logic [ADDR_W-1:0] IMG_BASE = 24'h00_0000,
   parameter logic [ADDR_W-1:0] IMG_LEN  = 24'h0F_0000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_cut_supply,
   input  logic                cfg_led_en,
   input  logic                recheck,
   output logic                sig_start,
   output logic [ADDR_W-1:0]   sig_addr,
   input  logic                sig_done,
   input  logic                sig_pass,
   output logic                hash_start,
   output logic [ADDR_W-1:0]   img_base,
   output logic [ADDR_W-1:0]   img_len,
   input  logic                hash_done,
   input  logic [DIGEST_W-1:0] hash_digest,
   input  logic [DIGEST_W-1:0] ref_digest,
   output logic                dec_start,
   input  logic                dec_done,
   input  logic                dec_pass,
   output logic                host_rst_n,
   output logic                dec_route_en,
   output logic [N_STAGE-1:0]  led_stage,
   output logic [N_SUPPLY-1:0] supply_en,
   output logic [2*N_STAGE-1:0] status_log
);
   localparam logic [STG_W-1:0] LAST_STG = STG_W'(N_STAGE - 1);

   // elaboration-time parameter checks
   if (WDOG_CYCLES < 2) begin : g_bad_wdog
      $error("WDOG_CYCLES must be at least 2");
   end
   if (N_SUPPLY < 1) begin : g_bad_sup
      $error("N_SUPPLY must be at least 1");
   end
   if (DIGEST_W % 8 != 0) begin : g_bad_dig
      $error("DIGEST_W must be a whole number of bytes");
   end

   seq_st_e          st_q, st_d;
   logic [STG_W-1:0] stg_q, stg_d;
   logic             log_we, log_clr, wd_exp;
   stage_res_e       log_val;
   logic [N_STAGE-1:0] done_v, pass_v, start_v;

   assign done_v = {dec_done, hash_done, sig_done};
   assign pass_v = {dec_pass, (hash_digest == ref_digest), sig_pass};

   always_comb begin
      st_d    = st_q;
      stg_d   = stg_q;
      log_we  = 1'b0;
      log_clr = 1'b0;
      log_val = RES_NONE;
      unique case (st_q)
         S_IDLE: begin
            st_d  = S_GO;
            stg_d = '0;
         end
         S_GO: st_d = S_WAIT;
         S_WAIT: begin
            if (done_v[stg_q]) begin
               log_we = 1'b1;
               if (pass_v[stg_q]) begin
                  log_val = RES_PASS;
                  if (stg_q == LAST_STG) st_d = S_OK;
                  else begin
                     stg_d = stg_q + STG_W'(1);
                     st_d  = S_GO;
                  end
               end else begin
                  log_val = RES_FAIL;
                  st_d    = S_FAIL;
               end
            end else if (wd_exp) begin
               log_we  = 1'b1;
               log_val = RES_TMO;
               st_d    = S_FAIL;
            end
         end
         S_OK: begin
            if (recheck) begin
               log_clr = 1'b1;
               stg_d   = '0;
               st_d    = S_GO;
            end
         end
         S_FAIL: st_d = S_FAIL;
         default: st_d = S_FAIL;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= S_IDLE;
         stg_q <= '0;
      end else begin
         st_q  <= st_d;
         stg_q <= stg_d;
      end
   end

   sboot_wdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (st_q == S_WAIT),
      .expired (wd_exp)
   );

   sboot_log #(.N(N_STAGE)) u_log (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (log_clr),
      .we    (log_we),
      .idx   (stg_q),
      .val   (log_val),
      .log_o (status_log)
   );

   for (genvar i = 0; i < N_STAGE; i++) begin : g_stage
      assign start_v[i]   = (st_q == S_GO) && (stg_q == STG_W'(i));
      assign led_stage[i] = cfg_led_en && (status_log[2*i +: 2] == RES_PASS);
   end

   assign sig_start    = start_v[0];
   assign hash_start   = start_v[1];
   assign dec_start    = start_v[2];
   assign sig_addr     = SIG_ADDR;
   assign img_base     = IMG_BASE;
   assign img_len      = IMG_LEN;
   assign host_rst_n   = (st_q == S_OK);
   assign dec_route_en = (st_q == S_OK);
   assign supply_en    = (st_q == S_FAIL && cfg_cut_supply) ? '0 : '1;
endmodule

// File: rtl/sboot_gate_chk.sv
module sboot_gate_chk #(
   parameter int unsigned N_SUPPLY = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                cfg_cut_supply,
   input logic                sig_start,
   input logic                hash_start,
   input logic                dec_start,
   input logic                host_rst_n,
   input logic [2:0]          led_stage,
   input logic [N_SUPPLY-1:0] supply_en,
   input logic [5:0]          status_log
);
   logic any_bad;
   assign any_bad = status_log[1] | status_log[3] | status_log[5];

   a_r2_sig_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      sig_start |=> !sig_start);

   a_r3_hash_after_sig: assert property (@(posedge clk) disable iff (!rst_n)
      hash_start |-> status_log[1:0] == 2'b01);

   a_r3_dec_after_hash: assert property (@(posedge clk) disable iff (!rst_n)
      dec_start |-> status_log[3:2] == 2'b01);

   a_r5_no_boot_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
      any_bad |-> !host_rst_n);

   a_r6_boot_all_passed: assert property (@(posedge clk) disable iff (!rst_n)
      host_rst_n |-> status_log == 6'b010101);

   a_r9_supply_cut: assert property (@(posedge clk) disable iff (!rst_n)
      (any_bad && cfg_cut_supply) |-> supply_en == '0);

   a_r10_led_only_on_pass: assert property (@(posedge clk) disable iff (!rst_n)
      led_stage[0] |-> status_log[1:0] == 2'b01);

   a_r12_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      any_bad |=> $stable(status_log) && !sig_start);
endmodule

bind sboot_gate sboot_gate_chk #(.N_SUPPLY(N_SUPPLY)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_cut_supply (cfg_cut_supply),
   .sig_start      (sig_start),
   .hash_start     (hash_start),
   .dec_start      (dec_start),
   .host_rst_n     (host_rst_n),
   .led_stage      (led_stage),
   .supply_en      (supply_en),
   .status_log     (status_log)
);

// File: tb/sboot_gate_bench.sv
module sboot_gate_bench;
   localparam int unsigned AW   = 24;
   localparam int unsigned DW   = 256;
   localparam int unsigned WD   = 20;
   localparam int unsigned NSUP = 4;
   localparam logic [AW-1:0] SADDR = 24'h0F_F000;
   localparam logic [DW-1:0] REF = {8{32'hA5C3_19E7}};

   // vector: r0 r1 r2 (0 pass, 1 fail, 2 silent), cut, led, exp_log, exp_led, exp_host
   localparam int NV = 8;
   localparam logic [17:0] VEC [0:NV-1] = '{
      {2'd0, 2'd0, 2'd0, 1'b1, 1'b1, 6'b010101, 3'b111, 1'b1},
      {2'd1, 2'd0, 2'd0, 1'b1, 1'b1, 6'b000010, 3'b000, 1'b0},
      {2'd0, 2'd1, 2'd0, 1'b0, 1'b1, 6'b001001, 3'b001, 1'b0},
      {2'd0, 2'd0, 2'd1, 1'b1, 1'b1, 6'b100101, 3'b011, 1'b0},
      {2'd2, 2'd0, 2'd0, 1'b0, 1'b1, 6'b000011, 3'b000, 1'b0},
      {2'd0, 2'd2, 2'd0, 1'b1, 1'b0, 6'b001101, 3'b000, 1'b0},
      {2'd0, 2'd0, 2'd2, 1'b0, 1'b1, 6'b110101, 3'b011, 1'b0},
      {2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 6'b010101, 3'b000, 1'b1}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_cut_supply = 1'b0, cfg_led_en = 1'b0, recheck = 1'b0;
   logic sig_done = 1'b0, sig_pass = 1'b0, hash_done = 1'b0, dec_done = 1'b0, dec_pass = 1'b0;
   logic [DW-1:0] hash_digest = '0;
   logic [DW-1:0] ref_digest = REF;
   logic sig_start, hash_start, dec_start, host_rst_n, dec_route_en;
   logic [AW-1:0] sig_addr, img_base, img_len;
   logic [2:0] led_stage;
   logic [NSUP-1:0] supply_en;
   logic [5:0] status_log;

   int n_chk = 0, n_fail = 0;
   int n_st [3];
   logic pend [3];

   always #5 clk = ~clk;

   sboot_gate #(.ADDR_W(AW), .DIGEST_W(DW), .WDOG_CYCLES(WD), .N_SUPPLY(NSUP),
                .SIG_ADDR(SADDR)) u_sboot_gate (
      .clk(clk), .rst_n(rst_n), .cfg_cut_supply(cfg_cut_supply), .cfg_led_en(cfg_led_en),
      .recheck(recheck), .sig_start(sig_start), .sig_addr(sig_addr), .sig_done(sig_done),
      .sig_pass(sig_pass), .hash_start(hash_start), .img_base(img_base), .img_len(img_len),
      .hash_done(hash_done), .hash_digest(hash_digest), .ref_digest(ref_digest),
      .dec_start(dec_start), .dec_done(dec_done), .dec_pass(dec_pass),
      .host_rst_n(host_rst_n), .dec_route_en(dec_route_en), .led_stage(led_stage),
      .supply_en(supply_en), .status_log(status_log));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clr_stub();
      for (int i = 0; i < 3; i++) begin n_st[i] = 0; pend[i] = 1'b0; end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      sig_done = 1'b0; hash_done = 1'b0; dec_done = 1'b0;
      clr_stub();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // engine stubs: answer one cycle after each start pulse
   task automatic drive_case(input logic [1:0] r0, input logic [1:0] r1,
                             input logic [1:0] r2, input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         sig_done = 1'b0; hash_done = 1'b0; dec_done = 1'b0;
         if (pend[0]) begin
            pend[0] = 1'b0;
            if (r0 != 2'd2) begin sig_done = 1'b1; sig_pass = (r0 == 2'd0); end
         end
         if (pend[1]) begin
            pend[1] = 1'b0;
            if (r1 != 2'd2) begin
               hash_done = 1'b1;
               hash_digest = (r1 == 2'd0) ? REF : (REF ^ {{(DW-1){1'b0}}, 1'b1});
            end
         end
         if (pend[2]) begin
            pend[2] = 1'b0;
            if (r2 != 2'd2) begin dec_done = 1'b1; dec_pass = (r2 == 2'd0); end
         end
         if (sig_start)  begin n_st[0]++; pend[0] = 1'b1; end
         if (hash_start) begin n_st[1]++; pend[1] = 1'b1; end
         if (dec_start)  begin n_st[2]++; pend[2] = 1'b1; end
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      // R1 reset state
      cfg_led_en = 1'b1; cfg_cut_supply = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 host_rst_n", 32'(host_rst_n), 0);
      chk("R1 status_log", 32'(status_log), 0);
      chk("R1 supply_en", 32'(supply_en), 32'hF);
      chk("R1 dec_route_en", 32'(dec_route_en), 0);
      chk("R1 led_stage", 32'(led_stage), 0);
      chk("R1 sig_start", 32'(sig_start), 0);

      // vector table: R3 R4 R5 R6 R7 R8 R9 R10
      for (int v = 0; v < NV; v++) begin
         logic [1:0] r0, r1, r2;
         logic cut, led, ehost;
         logic [5:0] elog;
         logic [2:0] eled;
         {r0, r1, r2, cut, led, elog, eled, ehost} = VEC[v];
         cfg_cut_supply = cut; cfg_led_en = led;
         do_reset();
         drive_case(r0, r1, r2, 3 * WD + 20);
         chk("R7 R8 R4 status_log", 32'(status_log), 32'(elog));
         chk("R5 R6 host_rst_n", 32'(host_rst_n), 32'(ehost));
         chk("R6 dec_route_en", 32'(dec_route_en), 32'(ehost));
         chk("R9 supply_en", 32'(supply_en), (!ehost && cut) ? 32'h0 : 32'hF);
         chk("R10 led_stage", 32'(led_stage), 32'(eled));
         chk("R2 sig starts", 32'(n_st[0]), 1);
         chk("R3 hash starts", 32'(n_st[1]), (r0 == 2'd0) ? 1 : 0);
         chk("R3 dec starts", 32'(n_st[2]), (r0 == 2'd0 && r1 == 2'd0) ? 1 : 0);
      end

      // R2 start timing and address
      cfg_cut_supply = 1'b0; cfg_led_en = 1'b1;
      do_reset();
      @(negedge clk);
      chk("R2 sig_start second cycle", 32'(sig_start), 1);
      chk("R2 sig_addr", 32'(sig_addr), 32'(SADDR));
      n_st[0] = 1; pend[0] = 1'b1;
      drive_case(2'd0, 2'd0, 2'd0, 20);
      chk("R6 booted before recheck", 32'(host_rst_n), 1);

      // R11 recheck after boot
      @(negedge clk); recheck = 1'b1;
      @(negedge clk); recheck = 1'b0;
      chk("R11 host reset again", 32'(host_rst_n), 0);
      chk("R11 log cleared", 32'(status_log), 0);
      chk("R11 leds cleared", 32'(led_stage), 0);
      chk("R11 restart signature", 32'(sig_start), 1);
      clr_stub(); n_st[0] = 1; pend[0] = 1'b1;
      drive_case(2'd0, 2'd0, 2'd0, 20);
      chk("R11 reboot", 32'(host_rst_n), 1);
      chk("R11 log after rerun", 32'(status_log), 32'h15);

      // R12 recheck ignored in failure
      cfg_cut_supply = 1'b1;
      do_reset();
      drive_case(2'd1, 2'd0, 2'd0, 10);
      clr_stub();
      @(negedge clk); recheck = 1'b1;
      @(negedge clk); recheck = 1'b0;
      drive_case(2'd0, 2'd0, 2'd0, 15);
      chk("R12 no restart", 32'(n_st[0]), 0);
      chk("R12 log kept", 32'(status_log), 32'h02);
      chk("R12 host held", 32'(host_rst_n), 0);
      chk("R12 supply still cut", 32'(supply_en), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule